// File: doc/BRIEF.md
# Hyperdimensional Image Encoder

This block turns one grayscale image into one binary hypervector. Pixels come in raster order on a valid/ready port. Each accepted pixel is mapped to a binary vector of `DIM` bits. The top bits of its intensity pick an intensity vector, and that vector is XORed with a location vector tied to the pixel's index in the frame. Each bit of the result is added into a per-bit counter. When the last pixel of the frame has been accepted, every output bit is decided by majority: it is 1 when more than half of the frame's pixels contributed a 1 in that position.

The vectors are made on chip, so no table is stored. The intensity vectors are built so that neighbouring intensity buckets differ in only a small, fixed number of bits, which keeps similar intensities similar in vector space. The location vectors are rotations of one base vector. The finished vector is held on the output until the consumer takes it. While it waits, no new pixels are accepted.

Top module: `hde_encoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The bucket k is the top 4 bits of the 8-bit pixel (16 buckets). Bit j of intensity vector k equals bit j of the base intensity vector, inverted when j < k·DIM/16. Bit j of the base intensity vector is bit 16 of the 32-bit product (j+1)·`LVL_SEED`. Adjacent buckets therefore differ in exactly DIM/16 bits.
- R3: For the pixel with frame index i (0 for the first pixel), bit j of the location vector equals bit ((j − i) mod DIM) of the base location vector. Bit m of that base vector is bit 16 of the 32-bit product (m+1)·`POS_SEED`. The bound bit is the intensity bit XOR the location bit.
- R4: Output bit j is 1 when more than 392 of the 784 pixels have bound bit j equal to 1. A count of exactly 392 gives 0.
- R5: `out_valid` rises in the cycle after the 784th pixel of a frame is accepted. When `out_ready` is high, it lasts exactly one cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_hv` holds its value and `in_ready` is low. Pixels offered during that time, with or without `in_sof`, are not accepted and do not affect the next frame.
- R7: A pixel accepted with `in_sof` high becomes index 0 of a new frame, and any partial frame is discarded.
- R8: After a frame completes, the next accepted pixel is index 0 even without `in_sof`.
- R9: Idle cycles with `in_valid` low between pixels do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The encoder can accept a pixel |
| in_sof | input | 1 | The offered pixel starts a frame |
| in_pix | input | 8 | Pixel intensity |
| out_valid | output | 1 | A finished image vector is present |
| out_ready | input | 1 | The consumer takes the vector |
| out_hv | output | DIM | Image hypervector |

## Verification
The bench builds the encoder with `DIM` = 64 and keeps the full 28×28 frame. This makes the location rotation wrap many times within one frame, and it makes every bit position small enough to reach in a run. Because bit 0 of an intensity vector flips between bucket 0 and every other bucket, the bench can choose buckets per pixel so that the count for bit 0 lands exactly on 392 or 393. That reaches the tie rule of the majority vote.

// File: rtl/hde_pkg.sv
package hde_pkg;

    localparam int PIX_W = 8;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } enc_state_e;

    typedef struct packed {
        logic             sof;
        logic [PIX_W-1:0] pix;
    } pix_beat_t;

    // Deterministic pseudo-random bit: bit 16 of (j+1)*seed, modulo 2^32.
    function automatic logic seed_bit(input int unsigned j, input logic [31:0] seed);
        logic [31:0] prod;
        prod = (j + 1) * seed;
        return prod[16];
    endfunction

endpackage

// File: rtl/hde_level_gen.sv
module hde_level_gen #(
    parameter int          DIM      = 512,
    parameter int          LEVELS   = 16,
    parameter logic [31:0] LVL_SEED = 32'h9E37_79B1,
    localparam int         BKT_W    = $clog2(LEVELS),
    localparam int         STEP     = DIM / LEVELS
) (
    input  logic [BKT_W-1:0] bucket,
    output logic [DIM-1:0]   level_hv
);
    logic [DIM-1:0] base;
    int             lim;

    for (genvar g = 0; g < DIM; g++) begin : g_base
        assign base[g] = hde_pkg::seed_bit(g, LVL_SEED);
    end

    always_comb begin
        lim = int'(bucket) * STEP;
        for (int j = 0; j < DIM; j++) begin
            level_hv[j] = base[j] ^ (j < lim);
        end
    end

    // R2: distance from the base vector grows by STEP per bucket
    always_comb begin
        if (!$isunknown(bucket)) begin
            assert_level_dist_R2: assert ($countones(level_hv ^ base) == int'(bucket) * STEP);
        end
    end

endmodule

// File: rtl/hde_pos_rot.sv
module hde_pos_rot #(
    parameter int          DIM      = 512,
    parameter logic [31:0] POS_SEED = 32'h85EB_CA77
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic           restart,
    input  logic           finish,
    output logic [DIM-1:0] pos_hv
);
    logic [DIM-1:0] base;
    logic [DIM-1:0] pos_q;

    for (genvar g = 0; g < DIM; g++) begin : g_base
        assign base[g] = hde_pkg::seed_bit(g, POS_SEED);
    end

    assign pos_hv = restart ? base : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= base;
        end else if (take) begin
            if (finish) pos_q <= base;
            else        pos_q <= {pos_hv[DIM-2:0], pos_hv[DIM-1]};
        end
    end

    // R3: rotation never changes the weight of the location vector
    assert_pos_weight_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(pos_q) == $countones(base));

endmodule

// File: rtl/hde_bundle.sv
module hde_bundle #(
    parameter int DIM    = 512,
    parameter int NPIX   = 784,
    localparam int CNT_W  = $clog2(NPIX + 1),
    localparam int THRESH = NPIX / 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic           restart,
    input  logic           finish,
    input  logic [DIM-1:0] bound_hv,
    output logic [DIM-1:0] hv_q
);
    for (genvar g = 0; g < DIM; g++) begin : g_bit
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] sum;

        assign sum = (restart ? '0 : cnt_q) + CNT_W'(bound_hv[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q   <= '0;
                hv_q[g] <= 1'b0;
            end else if (take) begin
                cnt_q <= finish ? '0 : sum;
                if (finish) hv_q[g] <= (sum > CNT_W'(THRESH));
            end
        end

        if (g == 0) begin : g_chk
            // R4: a partial count never reaches a full frame
            assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
                cnt_q < CNT_W'(NPIX));
        end
    end

endmodule

// File: rtl/hde_encoder.sv
module hde_encoder #(
    parameter int          DIM      = 512,
    parameter int          IMG_W    = 28,
    parameter int          IMG_H    = 28,
    parameter int          LEVELS   = 16,
    parameter logic [31:0] LVL_SEED = 32'h9E37_79B1,
    parameter logic [31:0] POS_SEED = 32'h85EB_CA77
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_sof,
    input  logic [hde_pkg::PIX_W-1:0] in_pix,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DIM-1:0]           out_hv
);
    import hde_pkg::*;

    localparam int NPIX  = IMG_W * IMG_H;
    localparam int IDX_W = $clog2(NPIX);
    localparam int BKT_W = $clog2(LEVELS);

    enc_state_e       state_q;
    pix_beat_t        beat;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cur_idx;
    logic             take;
    logic             finish;
    logic [DIM-1:0]   level_hv;
    logic [DIM-1:0]   pos_hv;

    assign beat      = '{sof: in_sof, pix: in_pix};
    assign in_ready  = (state_q == ST_RUN);
    assign out_valid = (state_q == ST_HOLD);
    assign take      = in_valid && in_ready;
    assign cur_idx   = beat.sof ? '0 : idx_q;
    assign finish    = take && (cur_idx == IDX_W'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
        end else begin
            if (take) idx_q <= finish ? '0 : cur_idx + 1'b1;
            case (state_q)
                ST_RUN:  if (finish)    state_q <= ST_HOLD;
                ST_HOLD: if (out_ready) state_q <= ST_RUN;
                default:                state_q <= ST_RUN;
            endcase
        end
    end

    hde_level_gen #(.DIM(DIM), .LEVELS(LEVELS), .LVL_SEED(LVL_SEED)) u_level (
        .bucket   (beat.pix[PIX_W-1 -: BKT_W]),
        .level_hv (level_hv)
    );

    hde_pos_rot #(.DIM(DIM), .POS_SEED(POS_SEED)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restart (beat.sof),
        .finish  (finish),
        .pos_hv  (pos_hv)
    );

    hde_bundle #(.DIM(DIM), .NPIX(NPIX)) u_bundle (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .restart  (beat.sof),
        .finish   (finish),
        .bound_hv (level_hv ^ pos_hv),
        .hv_q     (out_hv)
    );

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_hv));

    assert_valid_after_pixel_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(NPIX));

endmodule

// File: tb/hde_encoder_bench.sv
module hde_encoder_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          DIM        = 64;
    localparam int          NPIX       = 784;
    localparam int          STEP       = DIM / 16;
    localparam logic [31:0] LS         = 32'h9E37_79B1;
    localparam logic [31:0] PS         = 32'h85EB_CA77;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic           in_sof = 1'b0;
    logic [7:0]     in_pix = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [DIM-1:0] out_hv;

    int             checks = 0;
    int             errors = 0;
    int             cnt [DIM];
    int             bi = 0;
    int             hold = 0;
    int             tie_exp = -1;
    logic [DIM-1:0] exp_hv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hde_encoder #(.DIM(DIM)) u_hde_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid),
        .out_ready(out_ready), .out_hv(out_hv)
    );

    function automatic logic sbit(input int j, input logic [31:0] seed);
        logic [31:0] p;
        p = 32'(j + 1) * seed;
        return p[16];
    endfunction

    function automatic logic lvl(input int k, input int j);
        return sbit(j, LS) ^ (j < k * STEP);
    endfunction

    function automatic logic posb(input int i, input int j);
        return sbit(((j - (i % DIM)) + DIM) % DIM, PS);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DIM-1:0] act, input logic [DIM-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int j = 0; j < DIM; j++) cnt[j] = 0;
        bi = 0;
    endtask

    task automatic check_out();
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R5 valid after last pixel", DIM'(out_valid), DIM'(1));
        chk(out_hv === exp_hv, "R4 majority vector", out_hv, exp_hv);
        chk(in_ready === 1'b0, "R6 ready low while holding", DIM'(in_ready), DIM'(0));
        if (tie_exp >= 0)
            chk(out_hv[0] === tie_exp[0], "R4 tie rule on bit 0", DIM'(out_hv[0]), DIM'(tie_exp));
        if (hold > 0) begin
            out_ready = 1'b0;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = 1'b1;
                in_pix   = 8'($urandom);
                chk(out_valid === 1'b1 && out_hv === exp_hv, "R6 hold stable", out_hv, exp_hv);
                chk(in_ready === 1'b0, "R6 pixels refused", DIM'(in_ready), DIM'(0));
            end
            out_ready = 1'b1;
            in_valid  = 1'b0;
            in_sof    = 1'b0;
        end
        @(negedge clk);
        chk(out_valid === 1'b0, "R5 one-cycle valid", DIM'(out_valid), DIM'(0));
    endtask

    task automatic send(input logic [7:0] p, input bit s, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = p;
        in_sof   = s;
        while (in_ready !== 1'b1) @(negedge clk);
        @(posedge clk);
        if (s) clear_model();
        for (int j = 0; j < DIM; j++) cnt[j] += int'(lvl(int'(p[7:4]), j) ^ posb(bi, j));
        bi++;
        if (bi == NPIX) begin
            for (int j = 0; j < DIM; j++) exp_hv[j] = (cnt[j] > NPIX / 2);
            clear_model();
            check_out();
        end
    endtask

    // mode 0 random, 1 all 0xFF, 2/3 bit-0 count of 392/393
    task automatic run_frame(input int mode, input bit use_sof, input int maxgap, input int hld);
        hold    = hld;
        tie_exp = (mode >= 2) ? (mode - 2) : -1;
        for (int i = 0; i < NPIX; i++) begin
            logic [7:0] p;
            p = 8'($urandom);
            if (mode == 1) p = 8'hFF;
            if (mode >= 2) begin
                logic want;
                int   k;
                want = (i < ((mode == 2) ? 392 : 393));
                k    = ((lvl(0, 0) ^ posb(i, 0)) == want) ? 0 : 1 + int'($urandom % 15);
                p    = {4'(k), 4'($urandom)};
            end
            send(p, use_sof && (i == 0), (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0);
        end
        hold    = 0;
        tie_exp = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset out_valid", DIM'(out_valid), DIM'(0));
        chk(in_ready === 1'b1, "R1 reset in_ready", DIM'(in_ready), DIM'(1));
        run_frame(0, 1'b1, 0, 0);            // R2 R3 R4 random frame
        run_frame(0, 1'b0, 2, 3);            // R8 no sof, R9 gaps, R6 hold
        for (int i = 0; i < 100; i++)        // R7 partial frame then restart
            send(8'($urandom), i == 0, 0);
        run_frame(0, 1'b1, 1, 0);
        run_frame(1, 1'b1, 0, 0);            // R2 top bucket
        run_frame(2, 1'b1, 0, 2);            // R4 tie at 392
        run_frame(3, 1'b0, 0, 0);            // R4 393 votes
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule